// File: doc/BRIEF.md
# Variable-Length Configuration Flit Link

This block carries configuration frames over a narrow chain link as a train of 9-bit flits: 8 payload bits plus one end-of-frame marker. The marker is carried inside the flit, so a receiver finds the end of a frame without counting bits. The transmit side takes a whole frame in parallel and emits it as flits. The first flit holds the target block address. The second holds the register address, and its marker position carries the read/write bit, so a read request ends after two flits. A write continues with one to four data flits.

The receive side turns the flit stream back into a parallel frame and reports how many data bytes arrived. It flags a write whose data overruns the longest allowed length. A separate narrow return path carries sense results, one bit and one end marker per transfer. A deserializer gathers these bits into a word and reports the count. Every channel uses a valid/ready handshake, and a transfer takes place on a clock edge where both are high.

Top module: `flit_link`

## Requirements
- R1: After reset, the frame input is ready, no flit is offered, no rebuilt frame or sense word is pending, and both flit and sense inputs are ready.
- R2: The first flit of every frame is the block address in bits 7:0 with bit 8 equal to 0.
- R3: The second flit is the register address in bits 7:0. Bit 8 is 1 for a read and 0 for a write. A read frame consists of exactly these two flits.
- R4: A write frame with size code s (0 to 3) sends s+1 data flits, least significant byte first, for 3 to 6 flits in total. Bit 8 is 1 only on the last data flit.
- R5: While a frame is being sent, the frame input is not ready. A flit that has not been accepted stays offered and unchanged.
- R6: After the last flit is accepted, the receiver presents the block address, the register address, the read flag, the data with unreceived bytes at zero, and the byte count (0 for a read). These stay unchanged until taken.
- R7: If the fourth data flit of a write arrives with bit 8 at 0, the receiver presents the frame with four bytes and the error flag set. It then discards flits up to and including the next one with bit 8 at 1, and presents nothing for them.
- R8: While a rebuilt frame is pending, the flit input is not ready.
- R9: The sense deserializer stores incoming bits from bit 0 upward. It presents the word and the bit count after the transfer whose end bit is 1, and that transfer's data bit is included.
- R10: Sense bits beyond the word capacity are dropped. The count stops at the capacity and an overflow flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Parallel frame offered |
| frm_ready | output | 1 | Frame input free |
| frm_blk | input | 8 | Target block address |
| frm_reg | input | 8 | Register address |
| frm_read | input | 1 | 1 = read, 0 = write |
| frm_size | input | 2 | Data bytes minus one |
| frm_data | input | 32 | Write data |
| txf_valid | output | 1 | Outgoing flit valid |
| txf_ready | input | 1 | Outgoing flit taken |
| txf_flit | output | 9 | Outgoing flit, bit 8 = end marker |
| rxf_valid | input | 1 | Incoming flit valid |
| rxf_ready | output | 1 | Incoming flit accepted |
| rxf_flit | input | 9 | Incoming flit |
| rx_valid | output | 1 | Rebuilt frame pending |
| rx_ready | input | 1 | Rebuilt frame taken |
| rx_blk | output | 8 | Rebuilt block address |
| rx_reg | output | 8 | Rebuilt register address |
| rx_read | output | 1 | Rebuilt read flag |
| rx_data | output | 32 | Rebuilt data |
| rx_bytes | output | 3 | Data bytes received |
| rx_err | output | 1 | Data overran the maximum length |
| sn_valid | input | 1 | Sense transfer valid |
| sn_ready | output | 1 | Sense transfer accepted |
| sn_bit | input | 1 | Sense data bit |
| sn_eof | input | 1 | Sense end marker |
| sw_valid | output | 1 | Sense word pending |
| sw_ready | input | 1 | Sense word taken |
| sw_data | output | 32 | Collected sense bits |
| sw_len | output | 6 | Number of bits collected |
| sw_ovf | output | 1 | Bits were dropped |

## Verification
The bench keeps 8-bit flits and four data bytes, so every write length from one byte to the overrun case is reachable. It lowers the sense capacity to 8 bits so that overflow is reached with a ten-bit transfer. Transmit output loops back into the receiver for the vector table. For the overrun and discard cases, the bench drives flits into the receiver directly. A held rebuilt frame backs up the transmitter, which exposes the flit-hold behaviour.

// File: rtl/flit_link_pkg.sv
package flit_link_pkg;
   typedef enum logic [1:0] {
      RX_BLK   = 2'd0,
      RX_REG   = 2'd1,
      RX_DATA  = 2'd2,
      RX_DRAIN = 2'd3
   } rx_state_e;
endpackage

// File: rtl/flit_tx.sv
module flit_tx #(
   parameter int BYTE_W    = 8,
   parameter int MAX_BYTES = 4,
   localparam int SZ_W   = $clog2(MAX_BYTES),
   localparam int FLIT_W = BYTE_W + 1,
   localparam int DATA_W = BYTE_W * MAX_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_valid,
   output logic              frm_ready,
   input  logic [BYTE_W-1:0] frm_blk,
   input  logic [BYTE_W-1:0] frm_reg,
   input  logic              frm_read,
   input  logic [SZ_W-1:0]   frm_size,
   input  logic [DATA_W-1:0] frm_data,
   output logic              f_valid,
   input  logic              f_ready,
   output logic [FLIT_W-1:0] f_flit
);
   localparam int IDX_W = $clog2(MAX_BYTES + 2);

   logic              busy_q;
   logic [IDX_W-1:0]  idx_q, last_q, byte_sel;
   logic [BYTE_W-1:0] blk_q, reg_q;
   logic              rd_q;
   logic [DATA_W-1:0] data_q;
   logic [BYTE_W-1:0] lane [MAX_BYTES];

   for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
      assign lane[g] = data_q[g*BYTE_W +: BYTE_W];
   end

   assign frm_ready = !busy_q;
   assign f_valid   = busy_q;

   always_comb begin
      byte_sel = idx_q - IDX_W'(2);
      if (idx_q == '0)
         f_flit = {1'b0, blk_q};
      else if (idx_q == IDX_W'(1))
         f_flit = {rd_q, reg_q};
      else
         f_flit = {idx_q == last_q, lane[byte_sel[SZ_W-1:0]]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         last_q <= '0;
         blk_q  <= '0;
         reg_q  <= '0;
         rd_q   <= 1'b0;
         data_q <= '0;
      end else if (!busy_q) begin
         if (frm_valid) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            blk_q  <= frm_blk;
            reg_q  <= frm_reg;
            rd_q   <= frm_read;
            data_q <= frm_data;
            last_q <= frm_read ? IDX_W'(1) : IDX_W'(frm_size) + IDX_W'(2);
         end
      end else if (f_ready) begin
         if (idx_q == last_q) busy_q <= 1'b0;
         else                 idx_q  <= idx_q + IDX_W'(1);
      end
   end
endmodule

// File: rtl/flit_rx.sv
module flit_rx
   import flit_link_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int MAX_BYTES = 4,
   localparam int FLIT_W = BYTE_W + 1,
   localparam int DATA_W = BYTE_W * MAX_BYTES,
   localparam int CNT_W  = $clog2(MAX_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              f_valid,
   output logic              f_ready,
   input  logic [FLIT_W-1:0] f_flit,
   output logic              o_valid,
   input  logic              o_ready,
   output logic [BYTE_W-1:0] o_blk,
   output logic [BYTE_W-1:0] o_reg,
   output logic              o_read,
   output logic [DATA_W-1:0] o_data,
   output logic [CNT_W-1:0]  o_bytes,
   output logic              o_err
);
   rx_state_e         state_q;
   logic              acc, eof, clr;
   logic [BYTE_W-1:0] pay;
   logic [MAX_BYTES-1:0] we;

   assign f_ready = !o_valid;
   assign acc     = f_valid && f_ready;
   assign eof     = f_flit[BYTE_W];
   assign pay     = f_flit[BYTE_W-1:0];
   assign clr     = acc && (state_q == RX_BLK);

   for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
      assign we[g] = acc && (state_q == RX_DATA) && (o_bytes == CNT_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n || clr)  o_data[g*BYTE_W +: BYTE_W] <= '0;
         else if (we[g])     o_data[g*BYTE_W +: BYTE_W] <= pay;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RX_BLK;
         o_valid <= 1'b0;
         o_blk   <= '0;
         o_reg   <= '0;
         o_read  <= 1'b0;
         o_bytes <= '0;
         o_err   <= 1'b0;
      end else begin
         if (o_valid && o_ready) o_valid <= 1'b0;
         if (acc) begin
            unique case (state_q)
               RX_BLK: begin
                  o_blk   <= pay;
                  o_bytes <= '0;
                  o_err   <= 1'b0;
                  state_q <= RX_REG;
               end
               RX_REG: begin
                  o_reg  <= pay;
                  o_read <= eof;
                  if (eof) begin
                     o_valid <= 1'b1;
                     state_q <= RX_BLK;
                  end else begin
                     state_q <= RX_DATA;
                  end
               end
               RX_DATA: begin
                  o_bytes <= o_bytes + CNT_W'(1);
                  if (eof) begin
                     o_valid <= 1'b1;
                     state_q <= RX_BLK;
                  end else if (o_bytes == CNT_W'(MAX_BYTES - 1)) begin
                     o_err   <= 1'b1;
                     o_valid <= 1'b1;
                     state_q <= RX_DRAIN;
                  end
               end
               RX_DRAIN: begin
                  if (eof) state_q <= RX_BLK;
               end
               default: state_q <= RX_BLK;
            endcase
         end
      end
   end
endmodule

// File: rtl/sense_rx.sv
module sense_rx #(
   parameter int SENSE_MAX = 32,
   localparam int LEN_W = $clog2(SENSE_MAX + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 s_valid,
   output logic                 s_ready,
   input  logic                 s_bit,
   input  logic                 s_eof,
   output logic                 w_valid,
   input  logic                 w_ready,
   output logic [SENSE_MAX-1:0] w_data,
   output logic [LEN_W-1:0]     w_len,
   output logic                 w_ovf
);
   logic acc, clr, full;

   assign s_ready = !w_valid;
   assign acc     = s_valid && s_ready;
   assign clr     = w_valid && w_ready;
   assign full    = (w_len == LEN_W'(SENSE_MAX));

   for (genvar g = 0; g < SENSE_MAX; g++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n || clr)                    w_data[g] <= 1'b0;
         else if (acc && w_len == LEN_W'(g))   w_data[g] <= s_bit;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_valid <= 1'b0;
         w_len   <= '0;
         w_ovf   <= 1'b0;
      end else if (clr) begin
         w_valid <= 1'b0;
         w_len   <= '0;
         w_ovf   <= 1'b0;
      end else if (acc) begin
         if (full) w_ovf <= 1'b1;
         else      w_len <= w_len + LEN_W'(1);
         if (s_eof) w_valid <= 1'b1;
      end
   end
endmodule

// File: rtl/flit_link.sv
module flit_link #(
   parameter int BYTE_W    = 8,
   parameter int MAX_BYTES = 4,
   parameter int SENSE_MAX = 32,
   localparam int SZ_W   = $clog2(MAX_BYTES),
   localparam int FLIT_W = BYTE_W + 1,
   localparam int DATA_W = BYTE_W * MAX_BYTES,
   localparam int CNT_W  = $clog2(MAX_BYTES + 1),
   localparam int LEN_W  = $clog2(SENSE_MAX + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frm_valid,
   output logic                 frm_ready,
   input  logic [BYTE_W-1:0]    frm_blk,
   input  logic [BYTE_W-1:0]    frm_reg,
   input  logic                 frm_read,
   input  logic [SZ_W-1:0]      frm_size,
   input  logic [DATA_W-1:0]    frm_data,
   output logic                 txf_valid,
   input  logic                 txf_ready,
   output logic [FLIT_W-1:0]    txf_flit,
   input  logic                 rxf_valid,
   output logic                 rxf_ready,
   input  logic [FLIT_W-1:0]    rxf_flit,
   output logic                 rx_valid,
   input  logic                 rx_ready,
   output logic [BYTE_W-1:0]    rx_blk,
   output logic [BYTE_W-1:0]    rx_reg,
   output logic                 rx_read,
   output logic [DATA_W-1:0]    rx_data,
   output logic [CNT_W-1:0]     rx_bytes,
   output logic                 rx_err,
   input  logic                 sn_valid,
   output logic                 sn_ready,
   input  logic                 sn_bit,
   input  logic                 sn_eof,
   output logic                 sw_valid,
   input  logic                 sw_ready,
   output logic [SENSE_MAX-1:0] sw_data,
   output logic [LEN_W-1:0]     sw_len,
   output logic                 sw_ovf
);
   if (BYTE_W < 1 || MAX_BYTES < 2 || (MAX_BYTES & (MAX_BYTES - 1)) != 0) begin : g_bad_flit
      initial $fatal(1, "flit_link: BYTE_W >= 1 and MAX_BYTES a power of two >= 2 required");
   end
   if (SENSE_MAX < 1) begin : g_bad_sense
      initial $fatal(1, "flit_link: SENSE_MAX must be at least 1");
   end

   flit_tx #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .frm_valid(frm_valid), .frm_ready(frm_ready),
      .frm_blk(frm_blk), .frm_reg(frm_reg), .frm_read(frm_read),
      .frm_size(frm_size), .frm_data(frm_data),
      .f_valid(txf_valid), .f_ready(txf_ready), .f_flit(txf_flit)
   );

   flit_rx #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .f_valid(rxf_valid), .f_ready(rxf_ready), .f_flit(rxf_flit),
      .o_valid(rx_valid), .o_ready(rx_ready),
      .o_blk(rx_blk), .o_reg(rx_reg), .o_read(rx_read),
      .o_data(rx_data), .o_bytes(rx_bytes), .o_err(rx_err)
   );

   sense_rx #(.SENSE_MAX(SENSE_MAX)) u_sense (
      .clk(clk), .rst_n(rst_n),
      .s_valid(sn_valid), .s_ready(sn_ready), .s_bit(sn_bit), .s_eof(sn_eof),
      .w_valid(sw_valid), .w_ready(sw_ready),
      .w_data(sw_data), .w_len(sw_len), .w_ovf(sw_ovf)
   );
endmodule

// File: rtl/flit_link_chk.sv
module flit_link_chk #(
   parameter int BYTE_W    = 8,
   parameter int MAX_BYTES = 4,
   parameter int SENSE_MAX = 32,
   localparam int FLIT_W = BYTE_W + 1,
   localparam int DATA_W = BYTE_W * MAX_BYTES,
   localparam int CNT_W  = $clog2(MAX_BYTES + 1),
   localparam int LEN_W  = $clog2(SENSE_MAX + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 txf_valid,
   input logic                 txf_ready,
   input logic [FLIT_W-1:0]    txf_flit,
   input logic                 rx_valid,
   input logic                 rx_ready,
   input logic                 rx_read,
   input logic [DATA_W-1:0]    rx_data,
   input logic [CNT_W-1:0]     rx_bytes,
   input logic                 sw_valid,
   input logic                 sw_ready,
   input logic [SENSE_MAX-1:0] sw_data,
   input logic [LEN_W-1:0]     sw_len
);
   logic [3:0] seen_q;

   always_ff @(posedge clk) begin
      if (!rst_n) seen_q <= '0;
      else if (txf_valid && txf_ready)
         seen_q <= (seen_q != '0 && txf_flit[BYTE_W]) ? 4'd0 : seen_q + 4'd1;
   end

   AST_LEAD_EOF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      txf_valid && seen_q == '0 |-> !txf_flit[BYTE_W]);                          // R2
   AST_FLIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      txf_valid |-> seen_q <= 4'(MAX_BYTES + 1));                                  // R4
   AST_FLIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      txf_valid && !txf_ready |=> txf_valid && $stable(txf_flit));                 // R5
   AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rx_ready |=> rx_valid && $stable(rx_data) && $stable(rx_bytes)); // R6
   AST_RX_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rx_read |-> rx_bytes >= CNT_W'(1) && rx_bytes <= CNT_W'(MAX_BYTES)); // R6
   AST_SENSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sw_valid && !sw_ready |=> sw_valid && $stable(sw_data));                      // R9
   AST_SENSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      sw_valid |-> sw_len != '0 && sw_len <= LEN_W'(SENSE_MAX));                   // R10
endmodule

bind flit_link flit_link_chk #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES), .SENSE_MAX(SENSE_MAX)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .txf_valid(txf_valid), .txf_ready(txf_ready), .txf_flit(txf_flit),
   .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_read(rx_read),
   .rx_data(rx_data), .rx_bytes(rx_bytes),
   .sw_valid(sw_valid), .sw_ready(sw_ready), .sw_data(sw_data), .sw_len(sw_len)
);

// File: tb/tb_flit_link.sv
module tb_flit_link;
   localparam int SMAX = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic        frm_valid = 0, frm_read = 0;
   logic        frm_ready;
   logic [7:0]  frm_blk = 0, frm_reg = 0;
   logic [1:0]  frm_size = 0;
   logic [31:0] frm_data = 0;
   logic        txf_valid, txf_ready, rxf_valid, rxf_ready;
   logic [8:0]  txf_flit, rxf_flit;
   logic        rx_valid, rx_ready = 0, rx_read, rx_err;
   logic [7:0]  rx_blk, rx_reg;
   logic [31:0] rx_data;
   logic [2:0]  rx_bytes;
   logic        sn_valid = 0, sn_bit = 0, sn_eof = 0, sn_ready;
   logic        sw_valid, sw_ready = 0, sw_ovf;
   logic [SMAX-1:0] sw_data;
   logic [3:0]  sw_len;

   logic        direct = 0, d_valid = 0;
   logic [8:0]  d_flit = 0;
   assign rxf_valid = direct ? d_valid : txf_valid;
   assign rxf_flit  = direct ? d_flit  : txf_flit;
   assign txf_ready = direct ? 1'b0    : rxf_ready;

   flit_link #(.BYTE_W(8), .MAX_BYTES(4), .SENSE_MAX(SMAX)) dut (
      .clk(clk), .rst_n(rst_n),
      .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_blk(frm_blk), .frm_reg(frm_reg),
      .frm_read(frm_read), .frm_size(frm_size), .frm_data(frm_data),
      .txf_valid(txf_valid), .txf_ready(txf_ready), .txf_flit(txf_flit),
      .rxf_valid(rxf_valid), .rxf_ready(rxf_ready), .rxf_flit(rxf_flit),
      .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_blk(rx_blk), .rx_reg(rx_reg),
      .rx_read(rx_read), .rx_data(rx_data), .rx_bytes(rx_bytes), .rx_err(rx_err),
      .sn_valid(sn_valid), .sn_ready(sn_ready), .sn_bit(sn_bit), .sn_eof(sn_eof),
      .sw_valid(sw_valid), .sw_ready(sw_ready), .sw_data(sw_data), .sw_len(sw_len), .sw_ovf(sw_ovf)
   );

   // flit monitor on the transmit side
   logic       mon_clr = 0;
   logic [8:0] mon [8];
   int         mon_n = 0;
   always @(posedge clk) begin
      if (mon_clr) mon_n <= 0;
      else if (txf_valid && txf_ready && mon_n < 8) begin
         mon[mon_n] <= txf_flit;
         mon_n <= mon_n + 1;
      end
   end

   int checks = 0, failures = 0;
   task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // {blk, reg, read, size, data}
   localparam int NV = 6;
   localparam logic [50:0] VEC [NV] = '{
      {8'h3A, 8'h05, 1'b1, 2'd0, 32'h0000_0000},
      {8'h81, 8'h10, 1'b0, 2'd0, 32'h0000_00C3},
      {8'h02, 8'hFF, 1'b0, 2'd1, 32'h0000_BEEF},
      {8'hFF, 8'h00, 1'b0, 2'd2, 32'h0012_3456},
      {8'h00, 8'h7E, 1'b0, 2'd3, 32'hDEAD_BEEF},
      {8'h55, 8'hAA, 1'b1, 2'd3, 32'hFFFF_FFFF}
   };

   task automatic put_frame(input logic [50:0] v);
      @(negedge clk);
      {frm_blk, frm_reg, frm_read, frm_size, frm_data} = v;
      frm_valid = 1;
      mon_clr = 1;
      for (int t = 0; t < 100 && !frm_ready; t++) @(negedge clk);
      @(negedge clk);
      frm_valid = 0;
      mon_clr = 0;
   endtask

   task automatic wait_rx();
      for (int t = 0; t < 100 && !rx_valid; t++) @(negedge clk);
   endtask

   task automatic pop_rx();
      @(negedge clk) rx_ready = 1;
      @(negedge clk) rx_ready = 0;
   endtask

   task automatic send_flit(input logic [8:0] f);
      @(negedge clk);
      d_flit = f;
      d_valid = 1;
      for (int t = 0; t < 100 && !rxf_ready; t++) @(negedge clk);
      @(negedge clk);
      d_valid = 0;
   endtask

   task automatic send_sense(input logic b, input logic e);
      @(negedge clk);
      sn_bit = b; sn_eof = e; sn_valid = 1;
      for (int t = 0; t < 100 && !sn_ready; t++) @(negedge clk);
      @(negedge clk);
      sn_valid = 0;
   endtask

   initial begin
      #(200000 * 4);
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1
      chk(frm_ready && !txf_valid && !rx_valid && !sw_valid && rxf_ready && sn_ready, "R1 reset",
          {frm_ready, txf_valid, rx_valid, sw_valid, rxf_ready, sn_ready}, 6'b100011);

      for (int i = 0; i < NV; i++) begin
         logic [7:0] eb, er; logic rd; logic [1:0] sz; logic [31:0] dd, ed;
         int nf, nb;
         {eb, er, rd, sz, dd} = VEC[i];
         nb = rd ? 0 : int'(sz) + 1;
         nf = 2 + nb;
         ed = 0;
         for (int k = 0; k < nb; k++) ed[k*8 +: 8] = dd[k*8 +: 8];
         put_frame(VEC[i]);
         chk(!frm_ready, "R5 busy", frm_ready, 0);
         wait_rx();
         chk(mon_n == nf, "R4 flit count", mon_n, nf);
         chk(mon[0] == {1'b0, eb}, "R2 first flit", mon[0], {1'b0, eb});
         chk(mon[1] == {rd, er}, "R3 second flit", mon[1], {rd, er});
         for (int k = 0; k < nb; k++)
            chk(mon[k+2] == {k == nb - 1, dd[k*8 +: 8]}, "R4 data flit", mon[k+2], {k == nb - 1, dd[k*8 +: 8]});
         chk(rx_valid && rx_blk == eb && rx_reg == er && rx_read == rd && !rx_err, "R6 fields",
             {rx_valid, rx_blk, rx_reg, rx_read, rx_err}, {1'b1, eb, er, rd, 1'b0});
         chk(rx_data == ed && rx_bytes == 3'(nb), "R6 data", {rx_bytes, rx_data}, {3'(nb), ed});
         chk(!rxf_ready, "R8 blocked", rxf_ready, 0);
         pop_rx();
         chk(!rx_valid, "R6 taken", rx_valid, 0);
      end

      // R5: transmitter held back by pending rebuilt frame
      put_frame(VEC[1]);
      wait_rx();
      put_frame(VEC[2]);
      begin
         logic [8:0] held;
         held = txf_flit;
         repeat (4) @(negedge clk);
         chk(txf_valid && txf_flit == held && held == 9'h002, "R5 hold", txf_flit, 9'h002);
      end
      pop_rx();
      wait_rx();
      chk(rx_blk == 8'h02 && rx_data == 32'h0000BEEF && rx_bytes == 3'd2, "R5 resume",
          {rx_blk, rx_data}, {8'h02, 32'h0000BEEF});
      pop_rx();

      // R7: overrun then discard
      direct = 1;
      send_flit(9'h011); send_flit(9'h022);
      send_flit(9'h001); send_flit(9'h002); send_flit(9'h003); send_flit(9'h004);
      wait_rx();
      chk(rx_valid && rx_err && rx_bytes == 3'd4 && rx_data == 32'h04030201 && !rx_read, "R7 overrun",
          {rx_err, rx_bytes, rx_data}, {1'b1, 3'd4, 32'h04030201});
      pop_rx();
      send_flit(9'h0AA);
      @(negedge clk);
      chk(!rx_valid, "R7 drop1", rx_valid, 0);
      send_flit(9'h1BB);
      @(negedge clk);
      chk(!rx_valid, "R7 drop2", rx_valid, 0);
      send_flit(9'h044); send_flit(9'h166);
      wait_rx();
      chk(rx_blk == 8'h44 && rx_reg == 8'h66 && rx_read && rx_bytes == 0 && !rx_err, "R7 recover",
          {rx_blk, rx_reg, rx_read, rx_err}, {8'h44, 8'h66, 1'b1, 1'b0});
      pop_rx();
      direct = 0;

      // R9 sense
      send_sense(1, 0); send_sense(0, 0); send_sense(1, 0); send_sense(1, 1);
      for (int t = 0; t < 20 && !sw_valid; t++) @(negedge clk);
      chk(sw_valid && sw_data == 8'h0D && sw_len == 4 && !sw_ovf, "R9 word",
          {sw_ovf, sw_len, sw_data}, {1'b0, 4'd4, 8'h0D});
      chk(!sn_ready, "R9 blocked", sn_ready, 0);
      @(negedge clk) sw_ready = 1;
      @(negedge clk) sw_ready = 0;
      send_sense(0, 1);
      for (int t = 0; t < 20 && !sw_valid; t++) @(negedge clk);
      chk(sw_data == 8'h00 && sw_len == 1 && !sw_ovf, "R9 single", {sw_len, sw_data}, {4'd1, 8'h00});
      @(negedge clk) sw_ready = 1;
      @(negedge clk) sw_ready = 0;

      // R10 overflow
      for (int k = 0; k < 10; k++) send_sense(1, k == 9);
      for (int t = 0; t < 20 && !sw_valid; t++) @(negedge clk);
      chk(sw_data == 8'hFF && sw_len == 8 && sw_ovf, "R10 overflow",
          {sw_ovf, sw_len, sw_data}, {1'b1, 4'd8, 8'hFF});
      @(negedge clk) sw_ready = 1;
      @(negedge clk) sw_ready = 0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule